// File: doc/BRIEF.md
# Audio Converter Clock Generator

This block produces the clocks that audio converters need, all from one system clock running at 512 times the sample rate. In master mode a single free-running phase counter feeds three registered taps: a converter master clock at half the system rate (256·Fs), a bit clock at 64·Fs or 32·Fs, and a frame (left/right) clock at 1·Fs. Because every tap comes from the same counter, the phase between the clocks is fixed from the first edge after reset.

In slave mode the bit and frame clocks that an external source supplies are forwarded to the clock outputs without passing through a register, and the converter master clock is held low. A second master-clock output carries a full-rate copy of the system clock. An active-low enable turns it on, and it floats when the enable is high. Reset is synchronous and active high.

Top module: `audio_clkgen`

## Requirements
- R1: In master mode `mck_out` is 0 after reset, goes to 1 on the first system clock edge after reset is released, and then inverts on every edge, giving 256·Fs at 50% duty.
- R2: At every system clock edge where `rst` is 1, `mck_out` is driven to 0, and so are the master-mode bit and frame clocks.
- R3: After a system clock edge where `master_mode` is 0, `mck_out` is 0.
- R4: While `master_mode` is 0, `bck_out` equals `bck_in` and `lr_out` equals `lr_in`, with no clock-cycle delay.
- R5: `mck2_out` equals `clk` while `mck2_en_n` is 0, and is high impedance (z) while `mck2_en_n` is 1.
- R6: In master mode with `bck64_sel` = 1, after the n-th edge following reset release `bck_out` equals bit 2 of n. This is a period of 8 system clocks (64·Fs) at 50% duty, and the clock starts low.
- R7: In master mode with `bck64_sel` = 0, after the n-th edge `bck_out` equals bit 3 of n. This is a period of 16 system clocks (32·Fs).
- R8: In master mode, after the n-th edge `lr_out` equals bit 8 of n. This is a period of 512 system clocks, low for the first half. Each change of `lr_out` falls on the same edge as a falling edge of `bck_out`, so a frame holds 32 or 16 bit-clock periods per half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 512·Fs |
| rst | input | 1 | Synchronous reset, active high |
| master_mode | input | 1 | 1 = generate the clocks, 0 = forward the external clocks |
| bck64_sel | input | 1 | Master bit-clock rate: 1 = 64·Fs, 0 = 32·Fs |
| mck2_en_n | input | 1 | Active-low enable of the full-rate clock copy |
| bck_in | input | 1 | External bit clock (slave mode) |
| lr_in | input | 1 | External frame clock (slave mode) |
| mck_out | output | 1 | Converter master clock, 256·Fs |
| mck2_out | output | 1 | Full-rate copy of clk, or z |
| bck_out | output | 1 | Bit clock |
| lr_out | output | 1 | Frame clock |

## Verification
The bench builds the block with its default parameters: a ratio of 512 and bit-clock rates of 64 and 32. With these values a full frame-clock period fits within about 1100 system clocks. Each master run therefore covers more than two frame-clock transitions and a wrap of the phase counter, and the expected value of every output can be taken from bits of the bench's own edge count. A reset asserted in the middle of a frame then confirms that the outputs and their phase restart from zero.

// File: rtl/audio_clk_pkg.sv
package audio_clk_pkg;
  // Index of the counter bit that toggles at the requested output rate,
  // given the number of system clocks per frame.
  function automatic int tap_index(input int ratio, input int rate);
    return $clog2(ratio / rate) - 1;
  endfunction
endpackage

// File: rtl/clk_phase_ctr.sv
module clk_phase_ctr #(
  parameter int CW     = 9,
  parameter int MCK_B  = 0,
  parameter int HI_B   = 2,
  parameter int LO_B   = 3,
  parameter int LR_B   = 8
) (
  input  logic clk,
  input  logic rst,
  output logic mck_nx,
  output logic bhi_nx,
  output logic blo_nx,
  output logic lr_nx
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_next;

  assign cnt_next = rst ? '0 : cnt + CW'(1);

  always_ff @(posedge clk) begin
    cnt <= cnt_next;
  end

  assign mck_nx = cnt_next[MCK_B];
  assign bhi_nx = cnt_next[HI_B];
  assign blo_nx = cnt_next[LO_B];
  assign lr_nx  = cnt_next[LR_B];
endmodule

// File: rtl/clk_tap.sv
module clk_tap (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || !en) q <= 1'b0;
    else            q <= d;
  end
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int SYS_RATIO   = 512,
  parameter int BCK_RATE_HI = 64,
  parameter int BCK_RATE_LO = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic master_mode,
  input  logic bck64_sel,
  input  logic mck2_en_n,
  input  logic bck_in,
  input  logic lr_in,
  output logic mck_out,
  output logic mck2_out,
  output logic bck_out,
  output logic lr_out
);
  import audio_clk_pkg::*;

  localparam int CW    = $clog2(SYS_RATIO);
  localparam int MCK_B = 0;
  localparam int HI_B  = tap_index(SYS_RATIO, BCK_RATE_HI);
  localparam int LO_B  = tap_index(SYS_RATIO, BCK_RATE_LO);
  localparam int LR_B  = CW - 1;

  logic mck_nx, bhi_nx, blo_nx, lr_nx;
  logic bck_d;
  logic bck_m, lr_m;

  clk_phase_ctr #(
    .CW(CW), .MCK_B(MCK_B), .HI_B(HI_B), .LO_B(LO_B), .LR_B(LR_B)
  ) u_ctr (
    .clk(clk), .rst(rst),
    .mck_nx(mck_nx), .bhi_nx(bhi_nx), .blo_nx(blo_nx), .lr_nx(lr_nx)
  );

  assign bck_d = bck64_sel ? bhi_nx : blo_nx;

  clk_tap u_mck (.clk(clk), .rst(rst), .en(master_mode), .d(mck_nx), .q(mck_out));
  clk_tap u_bck (.clk(clk), .rst(rst), .en(master_mode), .d(bck_d),  .q(bck_m));
  clk_tap u_lr  (.clk(clk), .rst(rst), .en(master_mode), .d(lr_nx),  .q(lr_m));

  assign bck_out  = master_mode ? bck_m : bck_in;
  assign lr_out   = master_mode ? lr_m  : lr_in;
  assign mck2_out = mck2_en_n ? 1'bz : clk;
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
  input logic clk,
  input logic rst,
  input logic master_mode,
  input logic bck_in,
  input logic lr_in,
  input logic mck_out,
  input logic bck_out,
  input logic lr_out
);
  assert_mck_toggle_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(master_mode) && $past(master_mode, 2)) |-> (mck_out != $past(mck_out)));

  assert_reset_low_R2: assert property (@(posedge clk)
    $past(rst) |-> (!mck_out && (!master_mode || (!bck_out && !lr_out))));

  assert_slave_mck_low_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(master_mode) |-> !mck_out);

  assert_slave_pass_R4: assert property (@(posedge clk) disable iff (rst)
    !master_mode |-> (bck_out == bck_in && lr_out == lr_in));

  assert_frame_on_bck_fall_R8: assert property (@(posedge clk) disable iff (rst)
    (master_mode && $past(master_mode) && $past(master_mode, 2) && !$past(rst) && !$stable(lr_out))
      |-> $fell(bck_out));
endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
  .clk(clk), .rst(rst), .master_mode(master_mode),
  .bck_in(bck_in), .lr_in(lr_in),
  .mck_out(mck_out), .bck_out(bck_out), .lr_out(lr_out)
);

// File: tb/test_audio_clkgen.sv
`timescale 1ns/1ps
module test_audio_clkgen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master_mode = 1'b1;
  logic bck64_sel = 1'b1;
  logic mck2_en_n = 1'b1;
  logic bck_in = 1'b0;
  logic lr_in = 1'b0;
  logic mck_out, bck_out, lr_out;
  wire  mck2_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  audio_clkgen i_audio_clkgen (
    .clk(clk), .rst(rst), .master_mode(master_mode), .bck64_sel(bck64_sel),
    .mck2_en_n(mck2_en_n), .bck_in(bck_in), .lr_in(lr_in),
    .mck_out(mck_out), .mck2_out(mck2_out), .bck_out(bck_out), .lr_out(lr_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic do_reset(input int cycles);
    @(negedge clk);
    rst = 1'b1;
    repeat (cycles) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    master_mode = 1'b1; bck64_sel = 1'b1;
    do_reset(3);
    check("R2 mck in reset", mck_out, 1'b0);
    check("R2 bck in reset", bck_out, 1'b0);
    check("R2 lr in reset",  lr_out,  1'b0);
  endtask

  task automatic t_master(input logic sel, input int edges);
    master_mode = 1'b1; bck64_sel = sel;
    do_reset(2);
    for (int n = 1; n <= edges; n++) begin
      @(posedge clk);
      @(negedge clk);
      check("R1 mck", mck_out, n[0]);
      if (sel) check("R6 bck64", bck_out, n[2]);
      else     check("R7 bck32", bck_out, n[3]);
      check("R8 lr", lr_out, n[8]);
    end
  endtask

  task automatic t_mid_reset();
    master_mode = 1'b1; bck64_sel = 1'b1;
    do_reset(2);
    repeat (300) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R2 mid mck", mck_out, 1'b0);
    check("R2 mid bck", bck_out, 1'b0);
    check("R2 mid lr",  lr_out,  1'b0);
    rst = 1'b0;
    for (int n = 1; n <= 20; n++) begin
      @(posedge clk);
      @(negedge clk);
      check("R1 restart mck", mck_out, n[0]);
      check("R6 restart bck", bck_out, n[2]);
    end
  endtask

  task automatic t_slave();
    do_reset(2);
    master_mode = 1'b0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      bck_in = k[0];
      lr_in  = k[2];
      #1;
      check("R4 bck pass", bck_out, k[0]);
      check("R4 lr pass",  lr_out,  k[2]);
      check("R3 mck low",  mck_out, 1'b0);
    end
    master_mode = 1'b1;
  endtask

  task automatic t_mck2();
    mck2_en_n = 1'b1;
    @(negedge clk); #1;
    check("R5 disabled z", mck2_out, 1'bz);
    mck2_en_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      check("R5 copy low", mck2_out, 1'b0);
      @(posedge clk); #1;
      check("R5 copy high", mck2_out, 1'b1);
    end
    mck2_en_n = 1'b1;
    @(negedge clk); #1;
    check("R5 z again", mck2_out, 1'bz);
  endtask

  initial begin
    t_reset();
    t_master(1'b1, 1100);
    t_master(1'b0, 1100);
    t_mid_reset();
    t_slave();
    t_mck2();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule